// File: doc/BRIEF.md
# Row Miss Counter Stats Store

This block sits inside a memory controller that fronts a two-tier memory: a small fast tier used as a cache and a large slow tier. For each access to the slow tier it keeps a small saturating counter that records how often recently used rows missed in the row buffer. Each access presents a row address, a flag for write versus read, and a flag saying whether the access missed in the row buffer. The counters live in a set-associative table with least-recently-used replacement. A row that is not present gets an entry, and the oldest way in the set is evicted when all ways are in use.

A row-buffer miss adds a weight to the row's counter. Writes carry a heavier weight than reads, and row-buffer hits add nothing. When the updated counter rises above a threshold supplied at run time, the block raises a migration request that carries the row address. The request is held until the consumer accepts it. The entry is dropped at the moment of the trigger, so the same row cannot trigger again straight away. A free-running timer zeroes every counter once per period, so rows that are reused rarely cannot build up a large count over a long time.

Top module: `stats_store`

## Requirements
- R1: After reset, `migValid` is low, `accReady` is high and every entry of the table is invalid.
- R2: The low `log2(NUM_SETS)` bits of `accRow` select the set and the remaining bits form the tag. No set ever holds two valid entries with the same tag.
- R3: An accepted read (`accWrite`=0) with `accRbMiss`=1 adds `RD_INC` (default 1) to the row's counter.
- R4: An accepted write (`accWrite`=1) with `accRbMiss`=1 adds `WR_INC` (default 4) to the row's counter.
- R5: An accepted access with `accRbMiss`=0 leaves the row's counter unchanged.
- R6: When an accepted access leaves the counter strictly greater than `missThresh`, `migValid` goes high on the following cycle with `migRow` equal to the access's row. While `migReady` is low, `migValid` and `migRow` hold and `accReady` stays low. `migValid` drops one cycle after it is seen together with `migReady` high.
- R7: The entry whose update caused a trigger is invalidated in that same update, so the next access to that row allocates a new entry.
- R8: A counter saturates at `2^CNT_W-1` (31 by default) and does not wrap.
- R9: An allocation uses an invalid way if the set has one. Otherwise it evicts the least recently used way. Every accepted access, whether it hits a stored entry or allocates one, makes its way the most recently used.
- R10: Every `CLEAR_PERIOD` cycles after reset, one cycle zeroes all counters while keeping tags and valid bits, and `accReady` is low in that cycle.
- R11: A newly allocated entry starts from zero and takes the increment of the access that allocated it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| accValid | input | 1 | Slow-tier access present |
| accReady | output | 1 | Access accepted this cycle when high together with accValid |
| accRow | input | ROW_W | Row address of the access |
| accWrite | input | 1 | 1 = write, 0 = read |
| accRbMiss | input | 1 | 1 = the access missed in the row buffer |
| missThresh | input | CNT_W | Trigger threshold: a counter above this value requests migration |
| migValid | output | 1 | Migration request pending |
| migReady | input | 1 | Consumer accepts the migration request |
| migRow | output | ROW_W | Row address to migrate |

## Verification
A wrong counter or a wrong tag inside the table does not show up at once. It shows up only when the affected row is accessed again, as a migration pulse that comes one access too early, one access too late or not at all. The bench therefore drives each row up to the exact edge of the threshold and checks `migValid` on the cycle after every access. A fault in replacement order appears as a row that keeps its count when it should have been evicted, or loses it when it should have been kept. A counter that wraps instead of saturating, or a clear that does not happen, appears in the same way as a missing or extra trigger on a later access.

// File: rtl/stats_pkg.sv
package stats_pkg;

  // Strobes from the control to the datapath, at most one active per cycle.
  typedef struct packed {
    logic doUpdate;  // apply the presented access to the table
    logic doClear;   // zero every counter
  } stats_strobe_t;

endpackage

// File: rtl/stats_datapath.sv
module stats_datapath
  import stats_pkg::*;
#(
  parameter int NUM_WAYS = 16,
  parameter int NUM_SETS = 128,
  parameter int ROW_W    = 24,
  parameter int CNT_W    = 5,
  parameter int RD_INC   = 1,
  parameter int WR_INC   = 4
) (
  input  logic                clk,
  input  logic                rstN,
  input  stats_strobe_t       strobes,
  input  logic [ROW_W-1:0]    accRow,
  input  logic                accWrite,
  input  logic                accRbMiss,
  input  logic [CNT_W-1:0]    missThresh,
  output logic                trigger
);

  localparam int SET_W = $clog2(NUM_SETS);
  localparam int TAG_W = ROW_W - SET_W;
  localparam int WAY_W = $clog2(NUM_WAYS);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [WAY_W-1:0] AGE_OLDEST = WAY_W'(NUM_WAYS - 1);

  logic [TAG_W-1:0] tagMem   [NUM_SETS][NUM_WAYS];
  logic             validMem [NUM_SETS][NUM_WAYS];
  logic [CNT_W-1:0] cntMem   [NUM_SETS][NUM_WAYS];
  logic [WAY_W-1:0] ageMem   [NUM_SETS][NUM_WAYS];

  logic [SET_W-1:0]    setIdx;
  logic [TAG_W-1:0]    tagIn;
  logic [NUM_WAYS-1:0] matchVec;
  logic                hitFound, invFound;
  logic [WAY_W-1:0]    hitWay, invWay, lruWay, selWay;
  logic [WAY_W-1:0]    selAge;
  logic [CNT_W-1:0]    baseCnt, newCnt;
  logic [CNT_W:0]      incVal, sumCnt;

  assign setIdx = accRow[SET_W-1:0];
  assign tagIn  = accRow[ROW_W-1:SET_W];

  // Tag compare across the ways of the addressed set
  always_comb begin
    matchVec = '0;
    hitFound = 1'b0;
    hitWay   = '0;
    for (int w = 0; w < NUM_WAYS; w++) begin
      matchVec[w] = validMem[setIdx][w] && (tagMem[setIdx][w] == tagIn);
      if (matchVec[w] && !hitFound) begin
        hitFound = 1'b1;
        hitWay   = WAY_W'(w);
      end
    end
  end

  // Victim choice: lowest invalid way first, else the oldest way
  always_comb begin
    invFound = 1'b0;
    invWay   = '0;
    lruWay   = '0;
    for (int w = 0; w < NUM_WAYS; w++) begin
      if (!validMem[setIdx][w] && !invFound) begin
        invFound = 1'b1;
        invWay   = WAY_W'(w);
      end
      if (ageMem[setIdx][w] == AGE_OLDEST) lruWay = WAY_W'(w);
    end
  end

  assign selWay = hitFound ? hitWay : (invFound ? invWay : lruWay);
  assign selAge = ageMem[setIdx][selWay];

  // Weighted, saturating counter update
  assign baseCnt = hitFound ? cntMem[setIdx][hitWay] : '0;
  assign incVal  = !accRbMiss ? '0 : (accWrite ? (CNT_W+1)'(WR_INC) : (CNT_W+1)'(RD_INC));
  assign sumCnt  = {1'b0, baseCnt} + incVal;
  assign newCnt  = (sumCnt > {1'b0, CNT_MAX}) ? CNT_MAX : sumCnt[CNT_W-1:0];
  assign trigger = newCnt > missThresh;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int s = 0; s < NUM_SETS; s++) begin
        for (int w = 0; w < NUM_WAYS; w++) begin
          validMem[s][w] <= 1'b0;
          tagMem[s][w]   <= '0;
          cntMem[s][w]   <= '0;
          ageMem[s][w]   <= WAY_W'(w);
        end
      end
    end else begin
      if (strobes.doClear) begin
        for (int s = 0; s < NUM_SETS; s++) begin
          for (int w = 0; w < NUM_WAYS; w++) begin
            cntMem[s][w] <= '0;
          end
        end
      end
      if (strobes.doUpdate) begin
        tagMem[setIdx][selWay]   <= tagIn;
        cntMem[setIdx][selWay]   <= newCnt;
        validMem[setIdx][selWay] <= !trigger;
        for (int w = 0; w < NUM_WAYS; w++) begin
          if (WAY_W'(w) == selWay)
            ageMem[setIdx][w] <= '0;
          else if (ageMem[setIdx][w] < selAge)
            ageMem[setIdx][w] <= ageMem[setIdx][w] + 1'b1;
        end
      end
    end
  end

  // A set never holds two valid copies of one tag (R2)
  assert_unique_match_R2: assert property (@(posedge clk) disable iff (!rstN)
    strobes.doUpdate |-> $onehot0(matchVec));

  // A triggering update leaves its entry invalid (R7)
  assert_invalidate_R7: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.doUpdate && trigger) |=> !validMem[$past(setIdx)][$past(selWay)]);

  // A clear leaves counters at zero (R10)
  assert_clear_R10: assert property (@(posedge clk) disable iff (!rstN)
    strobes.doClear |=> (cntMem[0][0] == '0) && (cntMem[NUM_SETS-1][NUM_WAYS-1] == '0));

endmodule

// File: rtl/stats_ctrl.sv
module stats_ctrl
  import stats_pkg::*;
#(
  parameter int ROW_W        = 24,
  parameter int CLEAR_PERIOD = 10_000_000
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             accValid,
  output logic             accReady,
  input  logic [ROW_W-1:0] accRow,
  input  logic             trigger,
  input  logic             migReady,
  output logic             migValid,
  output logic [ROW_W-1:0] migRow,
  output stats_strobe_t    strobes
);

  localparam int PER_W = (CLEAR_PERIOD > 1) ? $clog2(CLEAR_PERIOD) : 1;
  localparam logic [PER_W-1:0] PER_LAST = PER_W'(CLEAR_PERIOD - 1);

  logic [PER_W-1:0] periodCnt;
  logic             clearNow;
  logic             accept;

  assign clearNow = (periodCnt == PER_LAST);
  assign accReady = !migValid && !clearNow;
  assign accept   = accValid && accReady;

  assign strobes.doUpdate = accept;
  assign strobes.doClear  = clearNow;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      periodCnt <= '0;
    end else if (clearNow) begin
      periodCnt <= '0;
    end else begin
      periodCnt <= periodCnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      migValid <= 1'b0;
      migRow   <= '0;
    end else if (accept && trigger) begin
      migValid <= 1'b1;
      migRow   <= accRow;
    end else if (migReady) begin
      migValid <= 1'b0;
    end
  end

  // An accepted trigger raises the request with that row (R6)
  assert_launch_R6: assert property (@(posedge clk) disable iff (!rstN)
    (accept && trigger) |=> (migValid && migRow == $past(accRow)));

  // A request not taken is held unchanged (R6)
  assert_hold_R6: assert property (@(posedge clk) disable iff (!rstN)
    (migValid && !migReady) |=> (migValid && $stable(migRow)));

endmodule

// File: rtl/stats_store.sv
module stats_store
  import stats_pkg::*;
#(
  parameter int NUM_WAYS     = 16,
  parameter int NUM_SETS     = 128,
  parameter int ROW_W        = 24,
  parameter int CNT_W        = 5,
  parameter int RD_INC       = 1,
  parameter int WR_INC       = 4,
  parameter int CLEAR_PERIOD = 10_000_000
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             accValid,
  output logic             accReady,
  input  logic [ROW_W-1:0] accRow,
  input  logic             accWrite,
  input  logic             accRbMiss,
  input  logic [CNT_W-1:0] missThresh,
  output logic             migValid,
  input  logic             migReady,
  output logic [ROW_W-1:0] migRow
);

  stats_strobe_t strobes;
  logic          trigger;

  stats_ctrl #(
    .ROW_W(ROW_W), .CLEAR_PERIOD(CLEAR_PERIOD)
  ) ctrl_i (
    .clk(clk), .rstN(rstN), .accValid(accValid), .accReady(accReady),
    .accRow(accRow), .trigger(trigger), .migReady(migReady),
    .migValid(migValid), .migRow(migRow), .strobes(strobes)
  );

  stats_datapath #(
    .NUM_WAYS(NUM_WAYS), .NUM_SETS(NUM_SETS), .ROW_W(ROW_W),
    .CNT_W(CNT_W), .RD_INC(RD_INC), .WR_INC(WR_INC)
  ) dp_i (
    .clk(clk), .rstN(rstN), .strobes(strobes), .accRow(accRow),
    .accWrite(accWrite), .accRbMiss(accRbMiss), .missThresh(missThresh),
    .trigger(trigger)
  );

endmodule

// File: tb/stats_store_tb_top.sv
module stats_store_tb_top;

  localparam int ROW_W  = 24;
  localparam int SET_W  = 7;
  localparam int PERIOD = 1000;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             accValid = 1'b0;
  logic             accReady;
  logic [ROW_W-1:0] accRow = '0;
  logic             accWrite = 1'b0;
  logic             accRbMiss = 1'b0;
  logic [4:0]       missThresh = 5'd31;
  logic             migValid;
  logic             migReady = 1'b1;
  logic [ROW_W-1:0] migRow;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  stats_store #(.CLEAR_PERIOD(PERIOD)) dut_i (
    .clk(clk), .rstN(rstN), .accValid(accValid), .accReady(accReady),
    .accRow(accRow), .accWrite(accWrite), .accRbMiss(accRbMiss),
    .missThresh(missThresh), .migValid(migValid), .migReady(migReady),
    .migRow(migRow)
  );

  function automatic logic [ROW_W-1:0] mkRow(int tag, int set);
    return ROW_W'((tag << SET_W) | set);
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // One accepted access; returns at the negedge after the accepting edge
  task automatic access(logic [ROW_W-1:0] row, bit wr, bit miss);
    @(negedge clk);
    while (!accReady) @(negedge clk);
    accValid = 1'b1; accRow = row; accWrite = wr; accRbMiss = miss;
    @(negedge clk);
    accValid = 1'b0;
  endtask

  task automatic expectMig(bit exp, logic [ROW_W-1:0] row, string req);
    check(migValid == exp, req, int'(migValid), int'(exp));
    if (exp) check(migRow == row, req, int'(migRow), int'(row));
  endtask

  // Wait for the periodic clear cycle so a test starts with zeroed counters
  task automatic syncClear();
    @(negedge clk);
    while (accReady || migValid) @(negedge clk);
  endtask

  task automatic testReset();
    check(migValid == 1'b0, "R1 migValid", int'(migValid), 0);
    check(accReady == 1'b1, "R1 accReady", int'(accReady), 1);
  endtask

  task automatic testReadWeight();
    logic [ROW_W-1:0] r = mkRow(5, 1);
    syncClear();
    missThresh = 5'd2;
    access(r, 0, 1); expectMig(0, r, "R3 R11 first read miss");
    access(r, 0, 1); expectMig(0, r, "R3 second read miss");
    access(r, 0, 1); expectMig(1, r, "R3 third read miss exceeds 2");
  endtask

  task automatic testWriteWeight();
    logic [ROW_W-1:0] a = mkRow(7, 2);
    logic [ROW_W-1:0] b = mkRow(8, 2);
    syncClear();
    missThresh = 5'd3;
    access(a, 1, 1); expectMig(1, a, "R4 R11 write on new entry gives 4");
    missThresh = 5'd4;
    access(b, 1, 1); expectMig(0, b, "R4 write gives 4 not above 4");
    access(b, 0, 1); expectMig(1, b, "R4 write then read gives 5");
  endtask

  task automatic testRbHit();
    logic [ROW_W-1:0] r = mkRow(9, 3);
    syncClear();
    missThresh = 5'd1;
    access(r, 0, 1); expectMig(0, r, "R5 read miss gives 1");
    for (int i = 0; i < 4; i++) begin
      access(r, i[0], 0); expectMig(0, r, "R5 row hit adds nothing");
    end
    access(r, 0, 1); expectMig(1, r, "R5 read miss gives 2");
  endtask

  task automatic testHoldAndInvalidate();
    logic [ROW_W-1:0] r = mkRow(11, 4);
    syncClear();
    missThresh = 5'd1;
    migReady = 1'b0;
    access(r, 0, 1);
    access(r, 0, 1); expectMig(1, r, "R6 trigger");
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      expectMig(1, r, "R6 held while not ready");
      check(accReady == 1'b0, "R6 accReady low while pending", int'(accReady), 0);
    end
    migReady = 1'b1;
    @(negedge clk);
    check(migValid == 1'b0, "R6 drops after taken", int'(migValid), 0);
    access(r, 0, 1); expectMig(0, r, "R7 entry restarted from zero");
    access(r, 0, 1); expectMig(1, r, "R7 fresh entry reaches 2");
  endtask

  task automatic testSaturate();
    logic [ROW_W-1:0] r = mkRow(13, 5);
    bit anyMig = 1'b0;
    syncClear();
    missThresh = 5'd31;
    for (int i = 0; i < 10; i++) begin
      access(r, 1, 1);
      if (migValid) anyMig = 1'b1;
    end
    check(!anyMig, "R8 no wrap past 31", int'(anyMig), 0);
    missThresh = 5'd30;
    access(r, 0, 0); expectMig(1, r, "R8 count held at 31");
  endtask

  task automatic testLru();
    syncClear();
    missThresh = 5'd31;
    for (int t = 0; t < 16; t++) access(mkRow(100 + t, 6), 0, 1);
    access(mkRow(100, 6), 0, 0);   // touch tag 100, tag 101 becomes oldest
    access(mkRow(116, 6), 0, 1);   // evicts tag 101
    missThresh = 5'd1;
    access(mkRow(100, 6), 0, 1); expectMig(1, mkRow(100, 6), "R9 touched row kept");
    access(mkRow(101, 6), 0, 1); expectMig(0, mkRow(101, 6), "R9 oldest row evicted");
    access(mkRow(102, 6), 0, 1); expectMig(1, mkRow(102, 6), "R9 other row kept");
  endtask

  task automatic testClear();
    logic [ROW_W-1:0] r = mkRow(20, 7);
    syncClear();
    check(accReady == 1'b0, "R10 accReady low in clear cycle", int'(accReady), 0);
    missThresh = 5'd4;
    access(r, 1, 1); expectMig(0, r, "R10 write gives 4");
    syncClear();
    access(r, 0, 1); expectMig(0, r, "R10 count zeroed by clear");
    access(r, 1, 1); expectMig(1, r, "R10 tag kept after clear");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testReadWeight();
    testWriteWeight();
    testRbHit();
    testHoldAndInvalidate();
    testSaturate();
    testLru();
    testClear();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule